// File: doc/BRIEF.md
# Quadrature Downconverter with Frame-Aligned Decimation

This block takes one real-valued ADC sample per clock, sitting on a fixed intermediate frequency, and turns it into complex baseband. An internal oscillator is built from a phase accumulator and a full-circle sine table. It multiplies each sample into an in-phase branch and a quadrature branch. Each branch is then summed over blocks of 64 products, which both filters and decimates by 64.

The default tuning word places the oscillator at 10.45 MHz for a 104.8576 MHz sample clock. That is half of a 500 kHz window below a 10.7 MHz IF, so the bottom of the window lands at DC. A frame-sync pulse restarts the oscillator phase and the block counter on the sample that carries it. Every frame therefore starts phase-coherent and produces the same number of outputs: 16384 for a 2^20-sample frame.

Top module: `ddc_zoom`

## Requirements
- R1: While reset is held and right after it is released, bb_valid is 0 and bb_i and bb_q are 0.
- R2: Before the first frame_sync after reset, bb_valid never rises, whatever the samples.
- R3: The sample presented with frame_sync has phase 0. Each later sample's phase is the previous one plus TUNE_WORD (default 428032000), modulo 2^32. The table index is the top 8 phase bits. The sine entry for index k is round(32767*sin(2*pi*k/256)), with halves rounded away from zero. The cosine entry is the sine entry at (k+64) mod 256.
- R4: The in-phase product is x*cos and the quadrature product is -(x*sin), where x is the 16-bit signed sample. Each product has 8192 added and is then shifted arithmetically right by 14, giving an 18-bit value.
- R5: The two lowest bits of adc_sample are treated as zero; a sample of value 3 gives outputs of zero.
- R6: Each output is the sum of the 64 rounded products of slots 0 to 63. Slot 0 is the sample that carries frame_sync, or the sample right after the previous block ended.
- R7: bb_valid is high for exactly one cycle per 64-sample block. It is visible two rising edges after the block's last sample is registered, and it is never high in two consecutive cycles.
- R8: A frame_sync that arrives in the middle of a block discards that block's partial sums, and no output is produced for it.
- R9: A frame of L consecutive samples, where L is a multiple of 64, starting at frame_sync and followed by fewer than 64 further samples, yields exactly L/64 outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, one sample per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| adc_sample | input | 16 | Two's-complement sample, 14 valid bits left-justified |
| frame_sync | input | 1 | Marks the first sample of a frame |
| bb_valid | output | 1 | One-cycle strobe for a decimated output |
| bb_i | output | 24 | In-phase block sum |
| bb_q | output | 24 | Quadrature block sum |

## Verification
The hardest case to reach from the ports is a frame_sync that lands part-way through a block. There, accumulated partial sums and an advanced phase must both be thrown away in the same cycle. The stimulus drives a sync followed by 30 samples, then a second sync and a full frame. The bench checks that the partial block yields nothing and that the next frame's outputs match a model restarted from phase 0. Samples at full negative scale and samples carrying only the two ignored low bits exercise the rounding and masking edges.

// File: rtl/ddc_zoom.sv
module ddc_zoom #(
  parameter int DATA_W   = 16,
  parameter int ADC_BITS = 14,
  parameter int PHASE_W  = 32,
  parameter int LUT_AW   = 8,
  parameter int LO_W     = 16,
  parameter int MIX_W    = 18,
  parameter int DEC_LOG2 = 6,
  parameter logic [PHASE_W-1:0] TUNE_WORD = PHASE_W'(428032000)
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [DATA_W-1:0]                adc_sample,
  input  logic                             frame_sync,
  output logic                             bb_valid,
  output logic signed [MIX_W+DEC_LOG2-1:0] bb_i,
  output logic signed [MIX_W+DEC_LOG2-1:0] bb_q
);
  localparam int  LUT_N  = 1 << LUT_AW;
  localparam int  OUT_W  = MIX_W + DEC_LOG2;
  localparam int  PROD_W = DATA_W + LO_W;
  localparam int  SHIFT  = PROD_W - MIX_W;
  localparam real AMP    = real'((2 ** (LO_W - 1)) - 1);
  localparam real TWO_PI = 6.28318530717958647692;

  function automatic logic signed [LO_W-1:0] tab_entry(input int k);
    real r;
    r = AMP * $sin(TWO_PI * real'(k) / real'(LUT_N));
    if (r >= 0.0) return LO_W'($rtoi(r + 0.5));
    else          return LO_W'(-$rtoi(-r + 0.5));
  endfunction

  logic signed [LO_W-1:0] sin_tab [LUT_N];
  for (genvar k = 0; k < LUT_N; k++) begin : g_lut
    assign sin_tab[k] = tab_entry(k);
  end

  logic [PHASE_W-1:0]  ph_acc, ph_cur;
  logic [DEC_LOG2-1:0] cnt, slot_cur, slot_r;
  logic                started, v1;

  assign ph_cur   = frame_sync ? '0 : ph_acc;
  assign slot_cur = frame_sync ? '0 : cnt;

  logic [LUT_AW-1:0] idx_s, idx_c;
  assign idx_s = ph_cur[PHASE_W-1 -: LUT_AW];
  assign idx_c = idx_s + LUT_AW'(LUT_N / 4);

  logic signed [DATA_W-1:0] x_m;
  assign x_m = {adc_sample[DATA_W-1 -: ADC_BITS], {(DATA_W-ADC_BITS){1'b0}}};

  logic signed [PROD_W-1:0] prod_i, prod_q, rnd_i, rnd_q;
  assign prod_i = PROD_W'(x_m) * PROD_W'(sin_tab[idx_c]);
  assign prod_q = -(PROD_W'(x_m) * PROD_W'(sin_tab[idx_s]));
  assign rnd_i  = prod_i + (PROD_W'(1) << (SHIFT - 1));
  assign rnd_q  = prod_q + (PROD_W'(1) << (SHIFT - 1));

  logic signed [MIX_W-1:0] mix_i, mix_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_acc  <= '0;
      cnt     <= '0;
      slot_r  <= '0;
      started <= 1'b0;
      v1      <= 1'b0;
      mix_i   <= '0;
      mix_q   <= '0;
    end else begin
      ph_acc  <= ph_cur + TUNE_WORD;
      cnt     <= slot_cur + 1'b1;
      slot_r  <= slot_cur;
      started <= started | frame_sync;
      v1      <= started | frame_sync;
      mix_i   <= rnd_i[PROD_W-1:SHIFT];
      mix_q   <= rnd_q[PROD_W-1:SHIFT];
    end
  end

  logic signed [OUT_W-1:0] acc_i, acc_q, sum_i, sum_q;
  logic                    first, last;
  assign first = (slot_r == '0);
  assign last  = (slot_r == '1);
  assign sum_i = (first ? '0 : acc_i) + OUT_W'(mix_i);
  assign sum_q = (first ? '0 : acc_q) + OUT_W'(mix_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_i    <= '0;
      acc_q    <= '0;
      bb_i     <= '0;
      bb_q     <= '0;
      bb_valid <= 1'b0;
    end else begin
      bb_valid <= v1 && last;
      if (v1) begin
        acc_i <= sum_i;
        acc_q <= sum_q;
        if (last) begin
          bb_i <= sum_i;
          bb_q <= sum_q;
        end
      end
    end
  end

  AST_PULSE_ONE: assert property (@(posedge clk) disable iff (!rst_n) bb_valid |=> !bb_valid); // R7
  AST_QUIET_UNSYNCED: assert property (@(posedge clk) disable iff (!rst_n) !started |-> !bb_valid); // R2
  AST_BLOCK_END: assert property (@(posedge clk) disable iff (!rst_n) bb_valid |-> $past(slot_r) == DEC_LOG2'((1 << DEC_LOG2) - 1)); // R6
  AST_PHASE_RESTART: assert property (@(posedge clk) disable iff (!rst_n) frame_sync |=> ph_acc == TUNE_WORD); // R3
endmodule

// File: tb/tb_ddc_zoom.sv
module tb_ddc_zoom;
  localparam int  FTW = 428032000;
  localparam real TWO_PI = 6.28318530717958647692;

  typedef struct { int due; longint i; longint q; } exp_t;

  logic        clk = 0, rst_n = 0, frame_sync = 0;
  logic [15:0] adc_sample = '0;
  logic        bb_valid;
  logic signed [23:0] bb_i, bb_q;

  ddc_zoom dut (.clk(clk), .rst_n(rst_n), .adc_sample(adc_sample), .frame_sync(frame_sync),
                .bb_valid(bb_valid), .bb_i(bb_i), .bb_q(bb_q));

  always #5 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0, out_cnt = 0;
  bit done = 0, prev_valid = 0;
  string cur_req = "R6";
  exp_t q[$];

  bit m_started = 0;
  int m_slot = 0;
  bit [31:0] m_phase = 0;
  longint m_acc_i = 0, m_acc_q = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string req, string what, longint act, longint exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp_v);
    end
  endtask

  function automatic longint lutv(int k);
    real r;
    r = 32767.0 * $sin(TWO_PI * real'(k) / 256.0);
    return (r >= 0.0) ? longint'($rtoi(r + 0.5)) : -longint'($rtoi(-r + 0.5));
  endfunction

  task automatic drive(int xv, bit sync);
    int xm, idx;
    longint pi_, pq_;
    @(negedge clk);
    adc_sample = 16'(xv);
    frame_sync = sync;
    if (sync) begin m_started = 1; m_slot = 0; m_phase = 0; end
    if (m_started) begin
      xm  = int'($signed(16'(xv)));
      xm  = xm - (xm & 3);
      idx = int'(m_phase[31:24]);
      pi_ = (longint'(xm) * lutv((idx + 64) % 256) + 8192) >>> 14;
      pq_ = (-(longint'(xm) * lutv(idx)) + 8192) >>> 14;
      if (m_slot == 0) begin m_acc_i = 0; m_acc_q = 0; end
      m_acc_i += pi_;
      m_acc_q += pq_;
      if (m_slot == 63) q.push_back('{due: cyc + 2, i: m_acc_i, q: m_acc_q});
      m_slot = (m_slot + 1) % 64;
      m_phase = m_phase + 32'(FTW);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (bb_valid) begin
        exp_t e;
        out_cnt++;
        chk(!prev_valid, "R7", "valid two cycles in a row", 1, 0);
        if (q.size() == 0) chk(0, cur_req, "unexpected output", 1, 0);
        else begin
          e = q.pop_front();
          chk(e.due == cyc, "R7", "output cycle", cyc, e.due);
          chk(longint'(bb_i) == e.i, cur_req, "bb_i (R4 R6)", bb_i, e.i);
          chk(longint'(bb_q) == e.q, cur_req, "bb_q (R4 R6)", bb_q, e.q);
        end
      end else if (q.size() != 0 && q[0].due <= cyc) begin
        chk(0, "R7", "missing output", cyc, q[0].due);
        void'(q.pop_front());
      end
      prev_valid = bb_valid;
    end
  end

  function automatic int gen(int mode, int n);
    case (mode)
      0: return 12345;
      1: return $rtoi(20000.0 * $cos(TWO_PI * 10.45 / 104.8576 * real'(n)));
      2: return int'($signed(16'($urandom)));
      3: return (n % 2) ? 32767 : -32768;
      4: return 3;
      default: return -32768;
    endcase
  endfunction

  task automatic run_frame(int len, int mode, string req);
    cur_req = req;
    out_cnt = 0;
    for (int n = 0; n < len; n++) drive(gen(mode, n), n == 0);
    for (int n = 0; n < 3; n++) drive(0, 0);
    chk(out_cnt == len / 64, "R9", {"outputs per frame ", req}, out_cnt, len / 64);
  endtask

  initial begin
    #1500000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(bb_valid == 0, "R1", "bb_valid in reset", bb_valid, 0);
    chk(bb_i == 0 && bb_q == 0, "R1", "outputs in reset", bb_i, 0);
    rst_n = 1;
    @(negedge clk);
    chk(bb_valid == 0 && bb_i == 0 && bb_q == 0, "R1", "after release", bb_i, 0);

    cur_req = "R2";
    out_cnt = 0;
    for (int n = 0; n < 200; n++) drive(gen(2, n), 0);
    repeat (3) @(negedge clk);
    chk(out_cnt == 0, "R2", "outputs before first sync", out_cnt, 0);

    run_frame(1024, 0, "R6");
    run_frame(1024, 1, "R3");
    run_frame(1024, 2, "R4");
    run_frame(1024, 3, "R4");
    run_frame(256,  5, "R4");

    run_frame(512, 4, "R5");
    chk(bb_i == 0 && bb_q == 0, "R5", "low bits only gives zero", bb_i, 0);

    cur_req = "R8";
    out_cnt = 0;
    for (int n = 0; n < 30; n++) drive(gen(2, n), n == 0);
    run_frame(1024, 2, "R8");
    run_frame(2048, 1, "R9");

    repeat (4) @(negedge clk);
    chk(q.size() == 0, "R6", "pending expected outputs", q.size(), 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule